// File: doc/BRIEF.md
# Alternating Reference-Difference Drift Canceller

This block removes slow drift from a time-domain converter whose input passes through an analog two-way switch. The block drives the switch select itself. On every conversion strobe it flips the switch, so successive sampling periods alternate between the measured signal and a fixed reference voltage. A conversion taken on the signal is held. The reference conversion that follows is subtracted from it, and the signed difference leaves the block as the raw corrected value. Any drift common to both conversions, such as supply wander or low-frequency converter noise, cancels in this difference.

The corrected stream then enters a long moving average. The default window is 1000 values and is not a power of two. A circular buffer sized to the window holds the recent values, and a running sum adds the newest value and removes the one being overwritten. A true divide by the window length produces the smoothed result. The averaged output is marked valid only once the window has been completely filled since reset.

Top module: `drift_canceller`

## Requirements
- R1: While reset is held and on the first clock after it, `sel_ref` is 0 (signal selected), and `diff_valid` and `avg_valid` are 0.
- R2: `sel_ref` inverts on every clock edge that samples `conv_valid` high and holds its value on every other edge. The value 0 selects the signal and the value 1 selects the reference.
- R3: A conversion strobed while `sel_ref` is 1 produces a one-cycle `diff_valid` pulse on the next cycle. With it comes `diff_data`, equal to the most recent conversion strobed while `sel_ref` was 0 minus this conversion, as a signed two's complement value one bit wider than `conv_data`.
- R4: A conversion strobed while `sel_ref` is 0 produces no `diff_valid` pulse.
- R5: `avg_valid` stays 0 until `AVG_LEN` (default 1000) difference values have been produced since reset. It first pulses for the difference value that completes that count.
- R6: Each difference value from the `AVG_LEN`-th onward yields exactly one `avg_valid` pulse, 3 cycles after its `diff_valid` pulse. `avg_data` equals the sum of the last `AVG_LEN` difference values divided by `AVG_LEN`, truncated toward zero.
- R7: The running sum never overflows. A full window of difference values all at +(2^DATA_W − 1), or all at −(2^DATA_W − 1), averages to exactly that value.
- R8: When the signal and reference conversions of every pair are equal, `diff_data` and `avg_data` are 0, however far the common level drifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data | input | DATA_W | Unsigned conversion result |
| sel_ref | output | 1 | Analog switch select: 0 signal, 1 reference |
| diff_data | output | DATA_W+1 | Signed signal-minus-reference difference |
| diff_valid | output | 1 | Strobe for `diff_data` |
| avg_data | output | DATA_W+1 | Signed moving average of the differences |
| avg_valid | output | 1 | Strobe for `avg_data` |

## Verification
The bench builds the block with the default 22-bit conversion width and the full 1000-entry window. This exercises the real fill threshold, many wraps of the circular buffer, and the true non-power-of-two divide. Full windows of the largest positive and negative differences push the 33-bit running sum to both of its extremes. Back-to-back strobes mixed with random gaps test pairing and switch toggling under the tightest possible conversion spacing.

// File: rtl/dc_pkg.sv
package dc_pkg;

  // Analog switch phase: which source the next conversion measures.
  typedef enum logic {
    PH_SIG = 1'b0,
    PH_REF = 1'b1
  } phase_e;

  function automatic phase_e next_phase(input phase_e p);
    return (p == PH_SIG) ? PH_REF : PH_SIG;
  endfunction

endpackage

// File: rtl/dc_pair_sub.sv
module dc_pair_sub
  import dc_pkg::*;
#(
  parameter int DW = 22
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DW-1:0]       in_data,
  output logic                sel_o,
  output logic signed [DW:0]  diff_o,
  output logic                diff_valid_o
);

  phase_e         phase_q;
  logic [DW-1:0]  sig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_SIG;
      sig_q        <= '0;
      diff_o       <= '0;
      diff_valid_o <= 1'b0;
    end else begin
      diff_valid_o <= 1'b0;
      if (in_valid) begin
        phase_q <= next_phase(phase_q);
        if (phase_q == PH_SIG) begin
          sig_q <= in_data;
        end else begin
          diff_o       <= $signed({1'b0, sig_q}) - $signed({1'b0, in_data});
          diff_valid_o <= 1'b1;
        end
      end
    end
  end

  assign sel_o = phase_q;

  // R2
  sel_flip_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (sel_o != $past(sel_o)));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sel_o));

  // R4
  diff_from_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_o == PH_SIG) |=> !diff_valid_o);

  // R3
  diff_single_chk: assert property (@(posedge clk) disable iff (rst)
    diff_valid_o |=> !diff_valid_o || $past(in_valid));

endmodule

// File: rtl/dc_ring_store.sv
module dc_ring_store #(
  parameter int DEPTH = 1000,
  parameter int W     = 23,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  // Read-before-write single port: returns the entry being replaced.
  always_ff @(posedge clk) begin
    if (we) begin
      rdata_o    <= mem[addr];
      mem[addr]  <= wdata;
    end
  end

endmodule

// File: rtl/dc_run_avg.sv
module dc_run_avg #(
  parameter int W   = 23,
  parameter int LEN = 1000,
  localparam int AW  = $clog2(LEN),
  localparam int CW  = $clog2(LEN + 1),
  localparam int SW  = W + $clog2(LEN),
  localparam int EXT = SW - W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic signed [W-1:0] avg_o,
  output logic                avg_valid_o
);

  localparam logic signed [SW-1:0] LEN_S   = SW'(LEN);
  localparam logic signed [SW-1:0] SUM_LIM = SW'(64'(LEN) << (W - 1));

  logic [AW-1:0]         wr_ptr;
  logic [CW-1:0]         fill_cnt;
  logic [W-1:0]          old_raw;
  logic signed [W-1:0]   new_q;
  logic                  s1_v, s1_evict, s1_full;
  logic                  s2_v, s2_full;
  logic signed [SW-1:0]  sum_q;
  logic signed [SW-1:0]  old_ext, new_ext, quot;

  dc_ring_store #(.DEPTH(LEN), .W(W)) u_store (
    .clk     (clk),
    .we      (in_valid),
    .addr    (wr_ptr),
    .wdata   (in_data),
    .rdata_o (old_raw)
  );

  // Stage 1: write into the ring, fetch the evicted entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      fill_cnt <= '0;
      new_q    <= '0;
      s1_v     <= 1'b0;
      s1_evict <= 1'b0;
      s1_full  <= 1'b0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        new_q    <= in_data;
        wr_ptr   <= (wr_ptr == AW'(LEN - 1)) ? '0 : wr_ptr + 1'b1;
        s1_evict <= (fill_cnt == CW'(LEN));
        s1_full  <= (fill_cnt >= CW'(LEN - 1));
        if (fill_cnt != CW'(LEN)) fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    new_ext = {{EXT{new_q[W-1]}}, new_q};
    old_ext = s1_evict ? {{EXT{old_raw[W-1]}}, old_raw} : '0;
  end

  // Stage 2: running sum update.
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      s2_v    <= 1'b0;
      s2_full <= 1'b0;
    end else begin
      s2_v    <= s1_v;
      s2_full <= s1_full;
      if (s1_v) sum_q <= sum_q + new_ext - old_ext;
    end
  end

  // Stage 3: divide by the window length (truncates toward zero).
  always_comb quot = sum_q / LEN_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_o       <= '0;
      avg_valid_o <= 1'b0;
    end else begin
      avg_valid_o <= s2_v && s2_full;
      if (s2_v) avg_o <= quot[W-1:0];
    end
  end

  // R5
  fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
    avg_valid_o |-> (fill_cnt == CW'(LEN)));

  // R6
  avg_lat_chk: assert property (@(posedge clk) disable iff (rst)
    avg_valid_o |-> $past(in_valid, 3));

  // R7
  sum_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sum_q <= SUM_LIM) && (sum_q >= -SUM_LIM));

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ptr <= AW'(LEN - 1));

endmodule

// File: rtl/drift_canceller.sv
module drift_canceller #(
  parameter int DATA_W  = 22,
  parameter int AVG_LEN = 1000,
  localparam int DIFF_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     conv_valid,
  input  logic [DATA_W-1:0]        conv_data,
  output logic                     sel_ref,
  output logic signed [DIFF_W-1:0] diff_data,
  output logic                     diff_valid,
  output logic signed [DIFF_W-1:0] avg_data,
  output logic                     avg_valid
);

  dc_pair_sub #(.DW(DATA_W)) u_pair (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (conv_valid),
    .in_data      (conv_data),
    .sel_o        (sel_ref),
    .diff_o       (diff_data),
    .diff_valid_o (diff_valid)
  );

  dc_run_avg #(.W(DIFF_W), .LEN(AVG_LEN)) u_avg (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (diff_valid),
    .in_data     (diff_data),
    .avg_o       (avg_data),
    .avg_valid_o (avg_valid)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sel_ref && !diff_valid && !avg_valid));

endmodule

// File: tb/drift_canceller_test.sv
module drift_canceller_test;

  localparam int DW  = 22;
  localparam int LEN = 1000;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_valid = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic sel_ref, diff_valid, avg_valid;
  logic signed [DW:0] diff_data, avg_data;

  always #2 clk = ~clk;

  drift_canceller #(.DATA_W(DW), .AVG_LEN(LEN)) uut (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .sel_ref(sel_ref), .diff_data(diff_data), .diff_valid(diff_valid),
    .avg_data(avg_data), .avg_valid(avg_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int exp_diff_q[$];
  longint exp_avg_q[$];
  int hist[LEN];
  int hptr = 0;
  longint msum = 0;
  int mcnt = 0;
  int avg_seen = 0;
  logic [2:0] pend = '0;
  bit exp_sel = 1'b0;

  function automatic longint avg_of(input longint s);
    return s / longint'(LEN);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: difference and average values, avg latency and fill gating.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(avg_valid == pend[2], "R5/R6 avg_valid timing", avg_valid, pend[2]);
      if (avg_valid) begin
        avg_seen++;
        if (exp_avg_q.size() > 0) begin
          longint e;
          e = exp_avg_q.pop_front();
          chk(longint'(avg_data) == e, "R6 avg_data", avg_data, e);
        end
      end
      pend = {pend[1:0], 1'b0};
      if (diff_valid) begin
        int e;
        if (exp_diff_q.size() > 0) begin
          e = exp_diff_q.pop_front();
          chk(int'(diff_data) == e, "R3 diff_data", diff_data, e);
        end else begin
          e = 0;
          chk(1'b0, "R4 unexpected diff_valid", 1, 0);
        end
        if (mcnt >= LEN) msum -= longint'(hist[hptr]);
        hist[hptr] = e;
        msum += longint'(e);
        hptr = (hptr + 1) % LEN;
        mcnt++;
        if (mcnt >= LEN) begin
          exp_avg_q.push_back(avg_of(msum));
          pend[0] = 1'b1;
        end
      end
    end
  end

  // One conversion strobe, then gap idle cycles.
  task automatic strobe(input int data, input int gap);
    bit was_ref;
    was_ref = exp_sel;
    conv_valid = 1'b1;
    conv_data  = DW'(data);
    if (was_ref) exp_diff_q.push_back(0);  // placeholder replaced below
    @(negedge clk);
    conv_valid = 1'b0;
    exp_sel = ~exp_sel;
    chk(sel_ref == exp_sel, "R2 sel_ref toggle", sel_ref, exp_sel);
    if (was_ref) chk(diff_valid == 1'b1, "R3 diff_valid after reference", diff_valid, 1);
    else         chk(diff_valid == 1'b0, "R4 no diff after signal", diff_valid, 0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk(sel_ref == exp_sel, "R2 sel_ref hold", sel_ref, exp_sel);
    end
  endtask

  task automatic pair(input int s, input int r, input int gap);
    strobe(s, gap);
    exp_sel = 1'b1;
    conv_valid = 1'b1;
    conv_data  = DW'(r);
    exp_diff_q.push_back(s - r);
    @(negedge clk);
    conv_valid = 1'b0;
    exp_sel = 1'b0;
    chk(sel_ref == 1'b0, "R2 sel_ref toggle", sel_ref, 0);
    chk(diff_valid == 1'b1, "R3 diff_valid after reference", diff_valid, 1);
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sel_ref == 1'b0, "R1 sel_ref in reset", sel_ref, 0);
    chk(diff_valid == 1'b0, "R1 diff_valid in reset", diff_valid, 0);
    chk(avg_valid == 1'b0, "R1 avg_valid in reset", avg_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sel_ref == 1'b0 && !diff_valid && !avg_valid, "R1 after reset", sel_ref, 0);

    // R3/R4/R5/R6: random pairs with random gaps, wraps the window.
    for (int k = 0; k < 1300; k++) begin
      int s, r;
      s = int'($urandom() & MAXV);
      r = int'($urandom() & MAXV);
      pair(s, r, int'($urandom_range(0, 3)));
      if (k == LEN - 2) chk(avg_seen == 0, "R5 no average before full window", avg_seen, 0);
    end
    // R7: full windows at both extremes
    for (int k = 0; k < LEN; k++) pair(MAXV, 0, 0);
    repeat (4) @(negedge clk);
    chk(avg_data == MAXV, "R7 positive extreme average", avg_data, MAXV);
    for (int k = 0; k < LEN; k++) pair(0, MAXV, 0);
    repeat (4) @(negedge clk);
    chk(avg_data == -MAXV, "R7 negative extreme average", avg_data, -MAXV);
    // R8: common drift cancels
    for (int k = 0; k < 1100; k++) begin
      int lvl;
      lvl = 2000000 + k * 300 + int'($urandom_range(0, 50));
      pair(lvl, lvl, int'($urandom_range(0, 1)));
    end
    repeat (4) @(negedge clk);
    chk(avg_data == 0, "R8 drift removed from average", avg_data, 0);
    chk(diff_data == 0, "R8 drift removed from difference", diff_data, 0);
    chk(avg_seen == mcnt - LEN + 1, "R6 one average per difference", avg_seen, mcnt - LEN + 1);
    chk(exp_avg_q.size() == 0, "R6 all averages delivered", exp_avg_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule